// File: doc/BRIEF.md
# Priority-Based Serial Bus Access Controller

This block decides when a node on a shared, idle-high serial line may begin sending a message. The line is driven low by any transmitting node. A message should only start once the line has stayed high for a quiet period, and that period grows with the message's priority level. Urgent traffic therefore wins the bus ahead of routine traffic.

The requester raises `req` with a 3-bit priority code. The block brings the received line through a synchronizer and counts bit times with a prescaler derived from the system clock. It grants the bus once the line has held high for the full window. If the line is seen low at any point in the window, the count starts again from zero. After the grant, the block reports busy until the requester signals that the message has ended. An abort input, driven by collision detection, returns the block to idle at once. The serial transmitter, the byte framing and the checksum are outside this block.

Top module: `bus_access_ctrl`

## Requirements
- R1: `bus_rx` passes through a two-flop synchronizer. A low level lasting one clock on `bus_rx` during the wait is still seen, and it restarts the window.
- R2: A bit time is DIV = CLK_HZ / BIT_RATE clocks. With the line high, `grant` rises on the (N*DIV + 2)-th rising clock edge counted from the first edge that samples `req` high in idle. N is the required number of bit times.
- R3: `req_prio` is a 3-bit unsigned code. The codes 1 to 7 mean levels 1 to 7, and level 1 is the most urgent. Code 0 means level 8, the least urgent. N = BASE_BITS + 2 * level, with BASE_BITS = 10. This gives 12 bit times for code 1, 20 for code 5 and 26 for code 0.
- R4: The priority is captured when a request is accepted from idle. Changes on `req_prio` during the wait do not alter the grant time.
- R5: Any low sample of the synchronized line during the wait clears the idle count. `grant` then rises on the (N*DIV + 3)-th rising edge counted from the first edge that samples `bus_rx` high again.
- R6: `grant` is a single-cycle pulse. `busy` rises in the same cycle as `grant` and stays high until `done` or `abort` is sampled. It is low in the cycle after that sample.
- R7: If `req` is sampled low during the wait, the block returns to idle and issues no grant. A later request runs a complete new window.
- R8: An `abort` sampled during the wait or while busy returns the block to idle. No grant is issued from that wait, and `busy` is low in the next cycle.
- R9: When `done` is sampled while `req` is still high, the next grant is not reused from the previous window. It comes on the (N*DIV + 3)-th rising edge counted from the edge that sampled `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx | input | 1 | Received serial line, high when idle |
| req | input | 1 | Request to transmit, held until done |
| req_prio | input | 3 | Priority code, 0 treated as level 8 |
| abort | input | 1 | Collision or abort indication |
| done | input | 1 | Requester reports the message finished |
| grant | output | 1 | One-cycle permission to start sending |
| busy | output | 1 | Bus owned by this node since grant |

## Verification
On every cycle, the assertions check several properties. The grant is a single-cycle pulse that coincides with busy. Busy holds until done or abort. A low synchronized line during the wait leaves the idle count at zero. The captured window length stays within the legal range and does not change during a wait. Dropped requests and aborts never produce a grant. The exact grant latency can only be shown by the bench scenarios, because it needs a clock-accurate count measured against the priority. These scenarios cover a restart caused by a single-clock glitch, the priority being ignored after capture, and a fresh window after done.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } bac_state_e;

  localparam int unsigned LOWEST_LEVEL = 8;

  // Map a 3-bit priority code onto a level 1..8 (0 stands for 8).
  function automatic int unsigned prio_level(input logic [2:0] code);
    int unsigned lvl;
    lvl = int'(unsigned'(code));
    if (lvl == 0) lvl = LOWEST_LEVEL;
    return lvl;
  endfunction

  // Quiet-line bit times required before sending.
  function automatic int unsigned window_bits(input int unsigned base,
                                              input logic [2:0] code);
    return base + 2 * prio_level(code);
  endfunction

  // Clocks per bit time, never below one.
  function automatic int unsigned clocks_per_bit(input int unsigned clk_hz,
                                                 input int unsigned rate);
    int unsigned d;
    d = clk_hz / rate;
    if (d == 0) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/bac_sync.sv
module bac_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bac_prescaler.sv
module bac_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (!run)           phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      end

      assign bit_tick = run && (phase == LAST);

      // R2: ticks are DIV clocks apart, never back to back
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
      // R2: a stopped prescaler restarts a full bit time
      assert_tick_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bit_tick);
    end else begin : g_pass
      assign bit_tick = run;
    end
  endgenerate
endmodule

// File: rtl/bac_idle_count.sv
module bac_idle_count #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bit_tick,
  input  logic [CW-1:0] goal,
  output logic [CW-1:0] quiet_bits,
  output logic          window_met
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       quiet_bits <= '0;
    else if (clear)                   quiet_bits <= '0;
    else if (bit_tick && !window_met) quiet_bits <= quiet_bits + 1'b1;
  end

  assign window_met = (quiet_bits == goal);

  // R2: the count saturates at the window length and never overshoots it
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && quiet_bits <= goal && $stable(goal)) |=> (quiet_bits <= goal));
endmodule

// File: rtl/bus_access_ctrl.sv
module bus_access_ctrl
  import bac_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BIT_RATE  = 9600,
  parameter int unsigned BASE_BITS = 10,
  parameter int unsigned SYNC_FF   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rx,
  input  logic       req,
  input  logic [2:0] req_prio,
  input  logic       abort,
  input  logic       done,
  output logic       grant,
  output logic       busy
);
  localparam int unsigned DIV      = clocks_per_bit(CLK_HZ, BIT_RATE);
  localparam int unsigned MAX_BITS = BASE_BITS + 2 * LOWEST_LEVEL;
  localparam int unsigned MIN_BITS = BASE_BITS + 2;
  localparam int unsigned CW       = $clog2(MAX_BITS + 1);

  bac_state_e    state, state_nx;
  logic          line_hi;
  logic          waiting;
  logic          counting;
  logic          bit_tick;
  logic          window_met;
  logic          accept_req;
  logic          give_grant;
  logic [CW-1:0] goal;
  logic [CW-1:0] quiet_bits;
  logic          grant_q;

  // R1: line synchronizer
  bac_sync #(.STAGES(SYNC_FF), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_rx),
    .dout  (line_hi)
  );

  assign waiting  = (state == ST_WAIT);
  assign counting = waiting && line_hi;

  // R2: bit-time ticks only while the line is quiet in the wait
  bac_prescaler #(.DIV(DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (counting),
    .bit_tick (bit_tick)
  );

  // R5: any low sample or leaving the wait clears the count
  bac_idle_count #(.CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!counting),
    .bit_tick   (bit_tick),
    .goal       (goal),
    .quiet_bits (quiet_bits),
    .window_met (window_met)
  );

  assign accept_req = (state == ST_IDLE) && req && !abort;
  assign give_grant = waiting && req && !abort && window_met;

  // R3/R4: window length captured at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          goal <= CW'(MAX_BITS);
    else if (accept_req) goal <= CW'(window_bits(BASE_BITS, req_prio));
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept_req) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (abort || !req)  state_nx = ST_IDLE;
        else if (window_met) state_nx = ST_BUSY;
      end
      ST_BUSY: if (abort || done) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      grant_q <= 1'b0;
    end else begin
      state   <= state_nx;
      grant_q <= give_grant;
    end
  end

  assign grant = grant_q;
  assign busy  = (state == ST_BUSY);

  // R6: single-cycle grant
  assert_grant_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  // R6: grant coincides with ownership
  assert_grant_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy);
  // R6: ownership holds until released
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !abort) |=> busy);
  // R5: a low line in the wait leaves no quiet bits counted
  assert_low_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !line_hi) |=> (quiet_bits == '0));
  // R3: captured window within the legal range
  assert_window_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (goal >= CW'(MIN_BITS) && goal <= CW'(MAX_BITS)));
  // R4: window fixed for the whole wait
  assert_window_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && $past(waiting)) |-> $stable(goal));
  // R7: dropped request yields no grant
  assert_drop_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !req) |=> (!grant && !busy));
  // R8: abort ends any wait or ownership
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!grant && !busy));
endmodule

// File: tb/tb_bus_access_ctrl.sv
module tb_bus_access_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 80;
  localparam int BIT_RATE   = 10;
  localparam int DIV        = CLK_HZ / BIT_RATE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rx = 1'b1;
  logic       req = 1'b0;
  logic [2:0] req_prio = 3'd1;
  logic       abort = 1'b0;
  logic       done = 1'b0;
  logic       grant, busy;

  int tests = 0;
  int fails = 0;

  bus_access_ctrl #(.CLK_HZ(CLK_HZ), .BIT_RATE(BIT_RATE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .req(req),
    .req_prio(req_prio), .abort(abort), .done(done),
    .grant(grant), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int need_bits(input logic [2:0] p);
    int lvl;
    lvl = (p == 3'd0) ? 8 : int'(p);
    return 10 + lvl * 2;
  endfunction

  function automatic int req_latency(input logic [2:0] p);
    return need_bits(p) * DIV + 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // counts negedges until grant is seen, up to a limit
  task automatic wait_grant(output int k);
    k = 0;
    while (k < 1000) begin
      @(negedge clk);
      k++;
      if (grant) break;
    end
  endtask

  // after grant: pulse, hold busy, release with done
  task automatic finish_msg(input string tag);
    check(busy === 1'b1, {tag, " R6 busy with grant"}, int'(busy), 1);
    @(negedge clk);
    check(grant === 1'b0 && busy === 1'b1, {tag, " R6 pulse/hold"}, int'({grant, busy}), 1);
    req = 1'b0; done = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, {tag, " R6 busy after done"}, int'(busy), 0);
    done = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_random();
    logic [2:0] p;
    int sel, k, lat, g, len, m, early;
    p = 3'($urandom % 8);
    sel = $urandom % 3;
    lat = req_latency(p);
    @(negedge clk);
    req_prio = p; req = 1'b1;
    if (sel == 0) begin
      wait_grant(k);
      check(k == lat, "R2 R3 random latency", k, lat);
    end else if (sel == 1) begin
      m = 1 + $urandom % 20;
      repeat (m) @(negedge clk);
      req_prio = p + 3'(1 + $urandom % 7);
      wait_grant(k);
      check(k + m == lat, "R4 priority change ignored", k + m, lat);
    end else begin
      g = 1 + $urandom % (lat - 4);
      early = 0;
      repeat (g) begin
        @(negedge clk);
        if (grant) early++;
      end
      len = 1 + $urandom % 3;
      bus_rx = 1'b0;
      repeat (len) begin
        @(negedge clk);
        if (grant) early++;
      end
      bus_rx = 1'b1;
      check(early == 0, "R5 no grant before glitch", early, 0);
      wait_grant(k);
      check(k == lat + 1, "R1 R5 restart latency", k, lat + 1);
    end
    if (grant) finish_msg("random");
    else begin
      req = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int k, lat, cnt;
    void'($urandom(32'd1708));
    repeat (3) @(negedge clk);
    check(grant === 1'b0 && busy === 1'b0, "R6 reset state", int'({grant, busy}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 code 1 is 12 bit times
    req_prio = 3'd1; req = 1'b1;
    wait_grant(k);
    check(k == 12 * DIV + 2, "R3 code1 12 bits", k, 12 * DIV + 2);
    finish_msg("code1");

    // R3 code 0 is level 8: 26 bit times
    req_prio = 3'd0; req = 1'b1;
    wait_grant(k);
    check(k == 26 * DIV + 2, "R3 code0 26 bits", k, 26 * DIV + 2);
    finish_msg("code0");

    // R3 code 5 is 20 bit times
    req_prio = 3'd5; req = 1'b1;
    wait_grant(k);
    check(k == 20 * DIV + 2, "R3 code5 20 bits", k, 20 * DIV + 2);
    finish_msg("code5");

    // R1 single-clock glitch late in the window restarts it
    lat = req_latency(3'd2);
    req_prio = 3'd2; req = 1'b1;
    repeat (lat - 4) @(negedge clk);
    bus_rx = 1'b0;
    @(negedge clk);
    bus_rx = 1'b1;
    wait_grant(k);
    check(k == lat + 1, "R1 one-clock low restarts", k, lat + 1);
    finish_msg("glitch");

    // R7 request dropped mid-wait
    lat = req_latency(3'd3);
    req_prio = 3'd3; req = 1'b1;
    repeat (20) @(negedge clk);
    req = 1'b0;
    cnt = 0;
    repeat (lat + 10) begin
      @(negedge clk);
      if (grant || busy) cnt++;
    end
    check(cnt == 0, "R7 no grant after drop", cnt, 0);
    req = 1'b1;
    wait_grant(k);
    check(k == lat, "R7 fresh window after drop", k, lat);
    finish_msg("drop");

    // R8 abort during the wait
    lat = req_latency(3'd4);
    req_prio = 3'd4; req = 1'b1;
    repeat (30) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    wait_grant(k);
    check(k == lat, "R8 abort restarts wait", k, lat);

    // R8 abort while busy
    @(negedge clk);
    abort = 1'b1; req = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && grant === 1'b0, "R8 abort clears busy", int'({grant, busy}), 0);
    abort = 1'b0;
    @(negedge clk);

    // R9 done with request still high runs a new window
    lat = req_latency(3'd6);
    req_prio = 3'd6; req = 1'b1;
    wait_grant(k);
    check(k == lat, "R9 first grant", k, lat);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check(busy === 1'b0, "R9 released", int'(busy), 0);
    wait_grant(k);
    check(k + 1 == lat + 1, "R9 next grant after done", k + 1, lat + 1);
    finish_msg("redo");

    for (int i = 0; i < 60; i++) run_random();

    summary();
    $finish;
  end
endmodule